// File: doc/BRIEF.md
# Two-Wire Serial Clock Generator

This block produces the serial clock for the controller side of a two-wire bus. A free-running prescaler divides the system clock down to a reference tick. The prescale value is normally picked as the system clock in MHz divided by ten, rounded to the nearest integer, so that the tick runs near 10 MHz. A divider register holds two independent 8-bit phase lengths, counted in reference ticks: one for the phase in which the clock line is pulled low, and one for the phase in which it is released. With equal counts, each count is 5,000,000 divided by the wanted bit rate. The usable range runs from roughly 20 kHz, where a count of 255 is the ceiling, up to roughly 400 kHz. At the top rate the count is rounded up by one, which gives a rate just under 400 kHz.

The clock line is open drain. The block only ever pulls it low or releases it, and it reads the wired line back. A target that holds the line low after release stretches the high phase, because the high-phase count pauses while the line reads low. Software writes the prescale value with the enable bit clear and then sets the enable bit. Clearing the enable bit and setting it again restarts the generator from idle, which acts as a soft reset of the bus timing.

Top module: `tw_sclgen`

## Requirements
- R1: After reset the clock line is released (`sclDriveLow`=0), and `tickStb`, `sclFallStb` and `sclRiseStb` are all 0.
- R2: A write with `cfgSel`=0 loads the control register: bit 7 is the enable and bits 6:0 are the prescale value P. While enabled, `tickStb` is a one-cycle pulse every max(P,1) system clocks. While disabled, `tickStb` stays 0.
- R3: A write with `cfgSel`=1 loads the divider register. The low phase of the clock lasts L·max(P,1) system clocks, where L is bits 7:0 of the divider and a value of 0 counts as 1.
- R4: The released (high) phase lasts H·max(P,1) system clocks, where H is bits 15:8 of the divider and a value of 0 counts as 1. This holds when no target stretches the clock.
- R5: `sclFallStb` pulses in the first cycle of each low phase and `sclRiseStb` pulses in the first cycle of each high phase. The two are never high together.
- R6: During the high phase, any reference tick on which `sclIn` reads low is not counted. A stretch that covers k ticks lengthens the phase by exactly k·max(P,1) clocks.
- R7: A divider write that lands during a phase does not change that phase. The new counts apply from the next phase boundary onward.
- R8: While the enable bit is 0, the line is released and no phase strobe occurs. After the enable is set, the first `sclFallStb` appears max(P,1) cycles after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Register write strobe |
| cfgSel | input | 1 | 0 selects the control register, 1 selects the divider register |
| cfgWrData | input | 16 | Write data |
| sclIn | input | 1 | Synchronized level of the wired clock line |
| tickStb | output | 1 | Reference tick pulse |
| sclFallStb | output | 1 | Pulse at the start of each low phase |
| sclRiseStb | output | 1 | Pulse at the start of each high phase |
| sclDriveLow | output | 1 | 1 pulls the clock line low, 0 releases it |

## Verification
A register write takes effect at the clock edge that ends the write cycle. A phase boundary occurs at the edge that ends the tick cycle on which the count expires, and the strobe for that boundary is visible in the cycle right after it. Phase lengths are therefore exact multiples of the tick period. The first fall after enable lands max(P,1) cycles after the write edge. The scoreboard measures the cycle distance between consecutive strobes at the falling clock edge and compares each one with the length queued when the stimulus was applied. Stretch windows are opened at the falling edge of the rise-strobe cycle, so the number of ticks lost can be computed exactly.

// File: rtl/tw_sclgen_pkg.sv
package tw_sclgen_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HIGH} phase_e;

  // commands from the control FSM to the phase counter
  typedef struct packed {
    logic loadLow;
    logic loadHigh;
    logic dec;
  } phaseCmd_t;
endpackage

// File: rtl/tw_sclgen_dp.sv
module tw_sclgen_dp
  import tw_sclgen_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  phaseCmd_t        cmd,
  input  logic [CNT_W-1:0] divLow,
  input  logic [CNT_W-1:0] divHigh,
  output logic             phaseDone
);
  logic [CNT_W-1:0] phaseCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             phaseCnt <= '0;
    else if (cmd.loadLow)  phaseCnt <= divLow;
    else if (cmd.loadHigh) phaseCnt <= divHigh;
    else if (cmd.dec)      phaseCnt <= phaseCnt - 1'b1;
  end

  // a count of 0 or 1 ends the phase on the next counted tick
  assign phaseDone = (phaseCnt <= CNT_W'(1));

  // R3: the FSM only decrements a count that has not yet expired
  p_dec_safe_r3: assert property (@(posedge clk) disable iff (!rstN)
    cmd.dec |-> (phaseCnt >= CNT_W'(2)));

  // R5: at most one command per cycle
  p_cmd_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(cmd));
endmodule

// File: rtl/tw_sclgen_ctrl.sv
module tw_sclgen_ctrl
  import tw_sclgen_pkg::*;
#(
  parameter int PRE_W = 7,
  parameter int CNT_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrEn,
  input  logic               cfgSel,
  input  logic [2*CNT_W-1:0] cfgWrData,
  input  logic               sclIn,
  input  logic               phaseDone,
  output phaseCmd_t          cmd,
  output logic [CNT_W-1:0]   divLow,
  output logic [CNT_W-1:0]   divHigh,
  output logic               tickStb,
  output logic               fallStb,
  output logic               riseStb,
  output logic               sclLow
);
  localparam int DIV_W = 2 * CNT_W;

  logic             enBit;
  logic [PRE_W-1:0] preVal;
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preTop;
  logic [DIV_W-1:0] divReg;
  phase_e           phase, nextPhase;

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enBit  <= 1'b0;
      preVal <= '0;
      divReg <= '0;
    end else if (cfgWrEn) begin
      if (cfgSel) divReg <= cfgWrData;
      else        {enBit, preVal} <= cfgWrData[PRE_W:0];
    end
  end

  assign divLow  = divReg[CNT_W-1:0];
  assign divHigh = divReg[DIV_W-1:CNT_W];

  // reference tick prescaler, held at zero while disabled
  assign preTop  = (preVal == '0) ? '0 : preVal - 1'b1;
  assign tickStb = enBit && (preCnt >= preTop);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 preCnt <= '0;
    else if (!enBit || tickStb) preCnt <= '0;
    else                       preCnt <= preCnt + 1'b1;
  end

  // phase sequencing
  always_comb begin
    cmd       = '0;
    nextPhase = phase;
    if (!enBit) begin
      nextPhase = PH_IDLE;
    end else if (tickStb) begin
      unique case (phase)
        PH_IDLE: begin
          nextPhase   = PH_LOW;
          cmd.loadLow = 1'b1;
        end
        PH_LOW: begin
          if (phaseDone) begin
            nextPhase    = PH_HIGH;
            cmd.loadHigh = 1'b1;
          end else begin
            cmd.dec = 1'b1;
          end
        end
        PH_HIGH: begin
          if (sclIn) begin
            if (phaseDone) begin
              nextPhase   = PH_LOW;
              cmd.loadLow = 1'b1;
            end else begin
              cmd.dec = 1'b1;
            end
          end
        end
        default: nextPhase = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      fallStb <= 1'b0;
      riseStb <= 1'b0;
    end else begin
      phase   <= nextPhase;
      fallStb <= cmd.loadLow;
      riseStb <= cmd.loadHigh;
    end
  end

  assign sclLow = (phase == PH_LOW);

  // R8: a cleared enable leads to idle with no strobes
  p_idle_release_r8: assert property (@(posedge clk) disable iff (!rstN)
    !enBit |=> (phase == PH_IDLE && !fallStb && !riseStb));

  // R6: a tick seen while the line is held low keeps the high phase going
  p_stretch_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_HIGH && tickStb && !sclIn) |=> (phase == PH_HIGH && !fallStb));

  // R5: every new low phase is announced in its first cycle
  p_fall_start_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclLow) |-> fallStb);

  // R5: the two phase strobes never coincide
  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(fallStb && riseStb));
endmodule

// File: rtl/tw_sclgen.sv
module tw_sclgen
  import tw_sclgen_pkg::*;
#(
  parameter int PRE_W = 7,
  parameter int CNT_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrEn,
  input  logic               cfgSel,
  input  logic [2*CNT_W-1:0] cfgWrData,
  input  logic               sclIn,
  output logic               tickStb,
  output logic               sclFallStb,
  output logic               sclRiseStb,
  output logic               sclDriveLow
);
  phaseCmd_t        cmd;
  logic [CNT_W-1:0] divLow, divHigh;
  logic             phaseDone;

  tw_sclgen_ctrl #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWrEn   (cfgWrEn),
    .cfgSel    (cfgSel),
    .cfgWrData (cfgWrData),
    .sclIn     (sclIn),
    .phaseDone (phaseDone),
    .cmd       (cmd),
    .divLow    (divLow),
    .divHigh   (divHigh),
    .tickStb   (tickStb),
    .fallStb   (sclFallStb),
    .riseStb   (sclRiseStb),
    .sclLow    (sclDriveLow)
  );

  tw_sclgen_dp #(.CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .divLow    (divLow),
    .divHigh   (divHigh),
    .phaseDone (phaseDone)
  );
endmodule

// File: tb/tw_sclgen_bench.sv
module tw_sclgen_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic        cfgSel = 1'b0;
  logic [15:0] cfgWrData = '0;
  logic        stretch = 1'b0;
  logic        sclIn;
  logic        tickStb, sclFallStb, sclRiseStb, sclDriveLow;

  always #5 clk = ~clk;

  // wired line: pulled low by the block or by a stretching target
  assign sclIn = !(sclDriveLow || stretch);

  tw_sclgen u_tw_sclgen (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel),
    .cfgWrData(cfgWrData), .sclIn(sclIn), .tickStb(tickStb),
    .sclFallStb(sclFallStb), .sclRiseStb(sclRiseStb), .sclDriveLow(sclDriveLow)
  );

  typedef struct {
    bit    isHigh;
    int    cycles;
    string req;
  } exp_t;

  exp_t expQ[$];
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int lastT = 0;
  bit lastValid = 0;
  int fallSeen = 0;
  int riseSeen = 0;
  int wd = 0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // scoreboard monitor: measures each completed phase
  always @(negedge clk) begin
    exp_t e;
    cyc++;
    if (sclFallStb || sclRiseStb) begin
      if (lastValid && expQ.size() > 0) begin
        e = expQ.pop_front();
        check(e.isHigh == sclFallStb, e.req, int'(sclFallStb), int'(e.isHigh));
        check(e.cycles == cyc - lastT, e.req, cyc - lastT, e.cycles);
      end
      lastT = cyc;
      lastValid = 1;
      if (sclFallStb) fallSeen++;
      else            riseSeen++;
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 50000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected <50000 cycles", wd);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wrReg(input bit sel, input logic [15:0] data);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgSel = sel; cfgWrData = data;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic push(input bit isHigh, input int cycles, input string req);
    exp_t e;
    e.isHigh = isHigh; e.cycles = cycles; e.req = req;
    expQ.push_back(e);
  endtask

  task automatic waitFall();
    int n = fallSeen;
    wait (fallSeen != n);
  endtask

  task automatic waitRise();
    int n = riseSeen;
    wait (riseSeen != n);
  endtask

  task automatic drain();
    while (expQ.size() != 0) @(negedge clk);
  endtask

  initial begin
    int cnt;
    bit quiet;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(sclDriveLow == 0, "R1", int'(sclDriveLow), 0);
    check(tickStb == 0, "R1", int'(tickStb), 0);
    check(sclFallStb == 0 && sclRiseStb == 0, "R1", int'(sclFallStb | sclRiseStb), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(sclDriveLow == 0, "R1", int'(sclDriveLow), 0);

    // P=3, low 4, high 2
    wrReg(1'b0, 16'h0003);
    wrReg(1'b1, 16'h0204);
    wrReg(1'b0, 16'h0083);
    waitFall();
    push(0, 12, "R3"); push(1, 6, "R4"); push(0, 12, "R3"); push(1, 6, "R4");
    drain();

    // R2 tick rate with P=3
    cnt = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (tickStb) cnt++; end
    check(cnt == 10, "R2", cnt, 10);

    // R6 stretch across two ticks: high lasts (2+2)*3
    waitRise();
    push(1, 12, "R6");
    stretch = 1'b1;
    repeat (6) @(negedge clk);
    stretch = 1'b0;
    drain();

    // R7 divider change mid low phase
    waitFall();
    push(0, 12, "R7"); push(1, 9, "R7"); push(0, 6, "R7");
    wrReg(1'b1, 16'h0302);
    drain();

    // R8 disable: line released, no strobes, no ticks
    wrReg(1'b0, 16'h0003);
    @(negedge clk);
    quiet = 1;
    for (int i = 0; i < 12; i++) begin
      if (sclDriveLow || sclFallStb || sclRiseStb || tickStb) quiet = 0;
      @(negedge clk);
    end
    check(quiet, "R8", int'(quiet), 1);
    check(sclDriveLow == 0, "R8", int'(sclDriveLow), 0);

    // R8 re-enable: first fall P cycles after the write edge
    wrReg(1'b0, 16'h0083);
    cnt = 0;
    while (!sclFallStb && cnt < 50) begin @(negedge clk); cnt++; end
    check(cnt == 3, "R8", cnt, 3);

    // P=1, low count 0 (acts as 1), high 1
    wrReg(1'b0, 16'h0001);
    wrReg(1'b1, 16'h0100);
    wrReg(1'b0, 16'h0081);
    waitFall();
    push(0, 1, "R3"); push(1, 1, "R4"); push(0, 1, "R3");
    drain();
    cnt = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (tickStb) cnt++; end
    check(cnt == 20, "R2", cnt, 20);

    // R5 strobes stay exclusive over a stretch of running
    quiet = 1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (sclFallStb && sclRiseStb) quiet = 0;
      if (sclFallStb && !sclDriveLow) quiet = 0;
      if (sclRiseStb && sclDriveLow) quiet = 0;
    end
    check(quiet, "R5", int'(quiet), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule